// File: doc/BRIEF.md
# Reset-Dominant PWM Cycle Controller

This block is the digital heart of one trailing-edge PWM phase. Each switching cycle starts with a pulse on the start input. That pulse sets the PWM latch and releases the ramp. Three digitised comparator results come into the block:

- the ramp has risen above the error signal;
- the ramp is close to its reference floor;
- the high-side current is too high.

From these the block produces two registered controls: a high-side request, which goes to a separate gate arbitration stage, and a ramp discharge control.

The block handles the cycle corners of this kind of modulator:

- **Reset dominance.** The latch is reset dominant, so a set and a reset in the same cycle leave the high side off.
- **Full duty.** If the latch is still set when the next start pulse arrives, the demand is taken to be full duty. The high side is forced off and the ramp is discharged. The high side comes back on as soon as the ramp reaches its floor.
- **Over-current.** An over-current while the high side is on ends the pulse at once and makes the block skip the next start pulse.
- **Saturated error signal.** When the error signal is saturated above the comparator range, the ramp comparison is ignored and the duty is 100%.

Minimum on-time and minimum off-time are enforced by counters that run on the sampling clock.

Top module: `pwm_cycle_core`

## Requirements
- R1: A rising edge on `start_i` (latch clear, no pending skip, no simultaneous ramp trip, off-time satisfied) makes `hs_req_o`=1 and `ramp_dis_o`=0 after the next clock. A later `ramp_above_i`=1 (outside blanking) makes `hs_req_o`=0 and `ramp_dis_o`=1 after the next clock. Both stay that way until the next start edge.
- R2: When a start edge and `ramp_above_i`=1 occur in the same cycle while the latch is clear, `hs_req_o` stays 0 and `ramp_dis_o` stays 1.
- R3: A start edge that finds the latch still set drives `hs_req_o`=0 and `ramp_dis_o`=1 after the next clock. This is the full-duty forced turn-off, and it is not subject to the on-time blanking.
- R4: After a full-duty turn-off, the high side stays off while `ramp_floor_i`=0. The first cycle with `ramp_floor_i`=1 gives `hs_req_o`=1 and `ramp_dis_o`=0 after the next clock.
- R5: A termination caused by the ramp comparator or by over-current never leaves `hs_req_o` high for fewer than MIN_ON consecutive cycles. `oc_i` is ignored during that blanking window and does not cause a skip.
- R6: `hs_req_o` stays low for at least MIN_OFF cycles. A start edge inside that window releases the ramp (`ramp_dis_o`=0) at once but delays the high side until the window ends.
- R7: While `ea_sat_i`=1, `ramp_above_i` has no effect and `hs_req_o` stays 1.
- R8: `oc_i`=1 while `hs_req_o`=1 and past blanking drives `hs_req_o`=0 and `ramp_dis_o`=1 after the next clock. The next start edge is then skipped. `oc_i` while the high side is off has no effect.
- R9: The skip is consumed by the start edge it suppresses. The start edge after that sets the latch normally.
- R10: The asynchronous active-low `rst_ni` clears the latch, the skip and the full-duty state, and drives `hs_req_o`=0 and `ramp_dis_o`=1.
- R11: `start_i` is edge sensitive. Holding it high counts as a single start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Cycle start pulse; rising edge is used |
| ramp_above_i | input | 1 | Ramp is above the error signal |
| ramp_floor_i | input | 1 | Ramp is within the floor band of the reference |
| ea_sat_i | input | 1 | Error signal is above the comparator range |
| oc_i | input | 1 | High-side over-current comparator |
| hs_req_o | output | 1 | High-side on request to gate arbitration |
| ramp_dis_o | output | 1 | Ramp discharge control (1 = hold discharged) |

## Verification
Both outputs are registered. Any input applied in a cycle shows up after exactly one clock edge. The exception is a turn-on delayed by the off-time window, which shows up one edge after the window closes. The bench drives inputs at the falling edge and samples one falling edge later. This puts every check exactly one rising edge after its stimulus. Blanking and off-time checks are counted edge by edge against MIN_ON=3 and MIN_OFF=2, so the bench expects the high side to end on the third high cycle and to return on the second low cycle.

// File: rtl/pwm_cycle_pkg.sv
package pwm_cycle_pkg;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_SKIP,
    EV_FULL,
    EV_SET,
    EV_VETO,
    EV_OC_TRIP,
    EV_TERM
  } cyc_ev_e;

  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/pwm_edge_det.sv
module pwm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);

  logic lvl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d <= 1'b0;
    else         lvl_d <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_d;

endmodule

// File: rtl/pwm_sat_timer.sv
module pwm_sat_timer #(
  parameter int unsigned LIMIT    = 4,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);

  localparam int unsigned W = pwm_cycle_pkg::cnt_w(LIMIT);

  generate
    if (LIMIT == 0) begin : g_none
      assign done_o = 1'b1;
    end else begin : g_cnt
      localparam logic [W-1:0] LIM   = W'(LIMIT);
      localparam logic [W-1:0] RST_V = RST_FULL ? LIM : '0;
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= RST_V;
        else if (clr_i)       cnt_q <= '0;
        else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      end

      assign done_o = (cnt_q == LIM);

      // R5 / R6: counter saturates, never wraps past its limit
      a_r5_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LIM);
    end
  endgenerate

endmodule

// File: rtl/pwm_latch_ctl.sv
module pwm_latch_ctl
  import pwm_cycle_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_p_i,
  input  logic rst_req_i,
  input  logic term_ok_i,
  input  logic oc_i,
  input  logic hs_q_i,
  input  logic floor_i,
  output logic latch_q_o,
  output logic fd_q_o,
  output logic skip_q_o,
  output logic latch_n_o,
  output logic fd_n_o
);

  cyc_ev_e ev;
  logic latch_q, fd_q, skip_q;
  logic latch_n, fd_n, skip_n;

  // start handling has priority; within it skip, then full duty, then reset-dominant set
  always_comb begin
    ev = EV_IDLE;
    if (start_p_i) begin
      if (skip_q)         ev = EV_SKIP;
      else if (latch_q)   ev = EV_FULL;
      else if (rst_req_i) ev = EV_VETO;
      else                ev = EV_SET;
    end else if (latch_q && hs_q_i && oc_i && term_ok_i) begin
      ev = EV_OC_TRIP;
    end else if (latch_q && rst_req_i && (term_ok_i || !hs_q_i)) begin
      ev = EV_TERM;
    end
  end

  always_comb begin
    latch_n = latch_q;
    fd_n    = fd_q;
    skip_n  = skip_q;
    unique case (ev)
      EV_SKIP:    begin latch_n = 1'b0; fd_n = 1'b0; skip_n = 1'b0; end
      EV_FULL:    begin latch_n = 1'b1; fd_n = 1'b1; end
      EV_SET:     begin latch_n = 1'b1; fd_n = 1'b0; end
      EV_VETO:    begin latch_n = 1'b0; fd_n = 1'b0; end
      EV_OC_TRIP: begin latch_n = 1'b0; fd_n = 1'b0; skip_n = 1'b1; end
      EV_TERM:    begin latch_n = 1'b0; fd_n = 1'b0; end
      default:    if (fd_q && floor_i) fd_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      fd_q    <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      latch_q <= latch_n;
      fd_q    <= fd_n;
      skip_q  <= skip_n;
    end
  end

  assign latch_q_o = latch_q;
  assign fd_q_o    = fd_q;
  assign skip_q_o  = skip_q;
  assign latch_n_o = latch_n;
  assign fd_n_o    = fd_n;

  // R9: a pending skip is consumed by the start it suppresses
  a_r9_skip_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p_i && skip_q |=> !skip_q && !latch_q);

  // R2: reset wins over a simultaneous set
  a_r2_reset_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p_i && !latch_q && rst_req_i |=> !latch_q);

endmodule

// File: rtl/pwm_cycle_core.sv
module pwm_cycle_core #(
  parameter int unsigned MIN_ON  = 6,
  parameter int unsigned MIN_OFF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ramp_above_i,
  input  logic ramp_floor_i,
  input  logic ea_sat_i,
  input  logic oc_i,
  output logic hs_req_o,
  output logic ramp_dis_o
);

  logic start_p;
  logic rst_req, term_ok;
  logic on_done, off_done;
  logic latch_q, fd_q, skip_q, latch_n, fd_n;
  logic hs_q, hs_n, dis_q, dis_n;

  pwm_edge_det u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (start_i),
    .pulse_o (start_p)
  );

  // saturated error signal masks the ramp comparator
  assign rst_req = ramp_above_i & ~ea_sat_i;
  assign term_ok = ~(hs_q & ~on_done);

  pwm_latch_ctl u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_p_i (start_p),
    .rst_req_i (rst_req),
    .term_ok_i (term_ok),
    .oc_i      (oc_i),
    .hs_q_i    (hs_q),
    .floor_i   (ramp_floor_i),
    .latch_q_o (latch_q),
    .fd_q_o    (fd_q),
    .skip_q_o  (skip_q),
    .latch_n_o (latch_n),
    .fd_n_o    (fd_n)
  );

  assign hs_n  = latch_n & ~fd_n & (hs_q | off_done);
  assign dis_n = ~latch_n | fd_n;

  pwm_sat_timer #(.LIMIT(MIN_ON), .RST_FULL(1'b0)) u_on_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~hs_n),
    .done_o (on_done)
  );

  pwm_sat_timer #(.LIMIT(MIN_OFF), .RST_FULL(1'b1)) u_off_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hs_n),
    .done_o (off_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      dis_q <= 1'b1;
    end else begin
      hs_q  <= hs_n;
      dis_q <= dis_n;
    end
  end

  assign hs_req_o   = hs_q;
  assign ramp_dis_o = dis_q;

  a_r1_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p && !latch_q && !skip_q && !rst_req && off_done |=> hs_q && !dis_q);

  a_r3_full_duty_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p && latch_q && !skip_q |=> !hs_q && dis_q);

  a_r4_floor_reon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fd_q && ramp_floor_i && !start_p && !rst_req && off_done |=> hs_q && !dis_q);

  a_r5_min_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_q) && !fd_q |-> $past(on_done));

  a_r6_min_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(off_done));

  a_r8_oc_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_q && oc_i && on_done && !start_p |=> !hs_q && skip_q);

endmodule

// File: tb/pwm_cycle_core_tb.sv
module pwm_cycle_core_tb_top;

  localparam int unsigned MIN_ON  = 3;
  localparam int unsigned MIN_OFF = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic ramp_above_i = 1'b0;
  logic ramp_floor_i = 1'b0;
  logic ea_sat_i = 1'b0;
  logic oc_i = 1'b0;
  logic hs_req_o, ramp_dis_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwm_cycle_core #(.MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .ramp_above_i (ramp_above_i),
    .ramp_floor_i (ramp_floor_i),
    .ea_sat_i     (ea_sat_i),
    .oc_i         (oc_i),
    .hs_req_o     (hs_req_o),
    .ramp_dis_o   (ramp_dis_o)
  );

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic end_pulse();
    ramp_above_i = 1'b1;
    for (int i = 0; i < 10 && hs_req_o; i++) step();
    ramp_above_i = 1'b0;
    chk("R1", "end_pulse hs", hs_req_o, 1'b0);
    idle(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    chk("R10", "reset hs", hs_req_o, 1'b0);
    chk("R10", "reset dis", ramp_dis_o, 1'b1);
    rst_ni = 1'b1;
    idle(3);

    // R1 basic set and trailing-edge reset
    pulse_start();
    chk("R1", "set hs", hs_req_o, 1'b1);
    chk("R1", "set dis", ramp_dis_o, 1'b0);
    idle(4);
    chk("R1", "hold hs", hs_req_o, 1'b1);
    ramp_above_i = 1'b1;
    step();
    chk("R1", "reset hs", hs_req_o, 1'b0);
    chk("R1", "reset dis", ramp_dis_o, 1'b1);
    ramp_above_i = 1'b0;
    idle(3);
    chk("R1", "stays off", hs_req_o, 1'b0);

    // R2 simultaneous set and reset
    start_i = 1'b1; ramp_above_i = 1'b1;
    step();
    chk("R2", "veto hs", hs_req_o, 1'b0);
    chk("R2", "veto dis", ramp_dis_o, 1'b1);
    start_i = 1'b0; ramp_above_i = 1'b0;
    step();
    chk("R2", "after veto hs", hs_req_o, 1'b0);
    idle(3);

    // R5 minimum on-time against the ramp comparator
    pulse_start();
    chk("R5", "on c1", hs_req_o, 1'b1);
    ramp_above_i = 1'b1;
    step();
    chk("R5", "on c2", hs_req_o, 1'b1);
    step();
    chk("R5", "on c3", hs_req_o, 1'b1);
    step();
    chk("R5", "off after MIN_ON", hs_req_o, 1'b0);
    ramp_above_i = 1'b0;

    // R6 start inside the off window
    pulse_start();
    chk("R6", "held off hs", hs_req_o, 1'b0);
    chk("R6", "ramp released", ramp_dis_o, 1'b0);
    step();
    chk("R6", "on after MIN_OFF", hs_req_o, 1'b1);
    end_pulse();

    // R3 / R4 full duty and floor re-entry
    pulse_start();
    chk("R3", "pre hs", hs_req_o, 1'b1);
    idle(5);
    pulse_start();
    chk("R3", "forced off hs", hs_req_o, 1'b0);
    chk("R3", "forced dis", ramp_dis_o, 1'b1);
    idle(2);
    chk("R4", "wait floor hs", hs_req_o, 1'b0);
    chk("R4", "wait floor dis", ramp_dis_o, 1'b1);
    ramp_floor_i = 1'b1;
    step();
    ramp_floor_i = 1'b0;
    chk("R4", "reon hs", hs_req_o, 1'b1);
    chk("R4", "reon dis", ramp_dis_o, 1'b0);
    end_pulse();

    // R7 saturated error signal
    pulse_start();
    ea_sat_i = 1'b1; ramp_above_i = 1'b1;
    idle(6);
    chk("R7", "sat holds hs", hs_req_o, 1'b1);
    ea_sat_i = 1'b0;
    step();
    chk("R7", "unsat ends hs", hs_req_o, 1'b0);
    ramp_above_i = 1'b0;
    idle(3);

    // R8 over-current trip and skip, R9 consumption
    pulse_start();
    idle(4);
    oc_i = 1'b1;
    step();
    oc_i = 1'b0;
    chk("R8", "trip hs", hs_req_o, 1'b0);
    chk("R8", "trip dis", ramp_dis_o, 1'b1);
    idle(3);
    pulse_start();
    chk("R8", "skipped hs", hs_req_o, 1'b0);
    chk("R8", "skipped dis", ramp_dis_o, 1'b1);
    idle(3);
    pulse_start();
    chk("R9", "after skip hs", hs_req_o, 1'b1);
    end_pulse();

    // R5 over-current blanked
    pulse_start();
    oc_i = 1'b1;
    step();
    oc_i = 1'b0;
    chk("R5", "oc blanked hs", hs_req_o, 1'b1);
    end_pulse();
    pulse_start();
    chk("R5", "no skip after blank", hs_req_o, 1'b1);
    end_pulse();

    // R8 over-current while off
    oc_i = 1'b1;
    step();
    oc_i = 1'b0;
    chk("R8", "oc off hs", hs_req_o, 1'b0);
    pulse_start();
    chk("R8", "no skip from off oc", hs_req_o, 1'b1);
    end_pulse();

    // R11 held start counts once
    start_i = 1'b1;
    idle(3);
    chk("R11", "held start hs", hs_req_o, 1'b1);
    start_i = 1'b0;
    step();
    chk("R11", "release hs", hs_req_o, 1'b1);
    end_pulse();

    // R10 reset mid-pulse clears pending skip
    pulse_start();
    idle(4);
    oc_i = 1'b1;
    step();
    oc_i = 1'b0;
    rst_ni = 1'b0;
    step();
    chk("R10", "mid reset hs", hs_req_o, 1'b0);
    chk("R10", "mid reset dis", ramp_dis_o, 1'b1);
    rst_ni = 1'b1;
    step();
    pulse_start();
    chk("R10", "skip cleared", hs_req_o, 1'b1);
    end_pulse();

    finish_run();
  end

endmodule